// File: doc/BRIEF.md
# Floppy Controller Host Register Window

This block is the processor-facing side of a floppy disk controller. It watches a 16-bit I/O address, claims an eight-byte window, and exposes four registers in it: command/status, track, sector and data. A byte written to the command register is classified by its high nibble into one of four command classes. Every command starts a busy countdown. Sector commands also open a transfer direction toward or away from the media.

The busy flag is produced by a down-counter clocked by the system clock. When the countdown runs out while a transfer direction is open, the block raises a DMA-ready request. The request is dropped by a force-interrupt command, by the end of a sector's worth of data bytes, or by a status read that shows no data request pending. The media itself sits outside the block. A stub supplies the bytes to be read and the error flags for the status register, and the block strobes it whenever a data byte is consumed or delivered.

Top module: `fdc_host_regs`

## Requirements
- R1: The block responds only when `addr & 16'hFFF8 == 16'h0FF8`. A read anywhere else, and a read of window offsets 4 to 7, returns 8'hFF. A write anywhere else changes no register.
- R2: On a command write, `cmd_type` takes the class of the high nibble `op = wdata[7:4]`: op 0 to 7 gives 1, op 8 to 11 gives 2, op 12, 14 and 15 give 3, and op 13 gives 4.
- R3: Every command write cancels any open transfer direction. A class 1 or class 3 command then holds `busy` high for exactly BUSY_CMD (20) clock cycles after the write edge.
- R4: A class 2 command holds `busy` for BUSY_XFER (500) cycles. It loads `media_flags` into status bits 7:2 and opens a direction: ops 8 and 9 open inbound, ops 10 and 11 open outbound.
- R5: `dma_req` rises on the same edge on which `busy` falls, and only if a direction is still open at that edge. A countdown that ends with no direction open leaves `dma_req` low.
- R6: Command op 0 (restore) clears the track register to 0 and sets `motor_on`.
- R7: Command op 13 (force interrupt) clears `busy`, the status register and `dma_req` on its write edge.
- R8: A status read (offset 0) returns `{status[7:2], drq, busy}`, where drq is 1 while a direction is open. If drq reads 0, `dma_req` drops on that read. A command that merely cancels the direction leaves `dma_req` unchanged.
- R9: While inbound, a data read (offset 3) returns `media_rdata` and pulses `media_rd`. While outbound, a data write pulses `media_wr`. After SECTOR_BYTES (256) such bytes the direction closes and `dma_req` drops.
- R10: After reset, `busy`, `dma_req` and `motor_on` are 0, `cmd_type` is 0, and the status, track and sector registers read 0.
- R11: Offsets 1 and 2 hold the track and sector bytes, which are written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | I/O address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational during `rd_en`) |
| media_rdata | input | 8 | Byte offered by the media stub |
| media_flags | input | 6 | Error flags loaded into status bits 7:2 by sector commands |
| media_rd | output | 1 | Inbound byte consumed |
| media_wr | output | 1 | Outbound byte delivered |
| dma_req | output | 1 | DMA-ready request |
| busy | output | 1 | Busy flag |
| motor_on | output | 1 | Motor flag set by restore |
| cmd_type | output | 3 | Class of the last command (0 after reset) |

## Verification
The bench measures the exact length of both busy periods. An off-by-one in the counter load or in the expiry detection shows up there as 19, 21, 499 or 501 cycles. It checks that `dma_req` rises on the very cycle `busy` falls after a sector command, and stays low after a plain command; a design that raised the request on any expiry, or one cycle late, would be caught there. The bench also covers the case where a cancelling command leaves a raised request in place until a status read shows drq clear; a design that dropped the request too early, or never, fails that check. Finally it streams full sectors in both directions, which catches an off-by-one byte count or a direction left open at the end.

// File: rtl/fdc_host_pkg.sv
// Shared types for the floppy controller host register window.
// Assumes: command class is decided purely by the high nibble of the command byte.
package fdc_host_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_IN   = 2'd1,
        DIR_OUT  = 2'd2
    } xfer_dir_t;

    typedef enum logic [2:0] {
        CT_NONE = 3'd0,
        CT_T1   = 3'd1,
        CT_T2   = 3'd2,
        CT_T3   = 3'd3,
        CT_T4   = 3'd4
    } cmd_type_t;

    localparam logic [3:0] OP_RESTORE   = 4'h0;
    localparam logic [3:0] OP_FORCE_INT = 4'hD;

    // Map a command nibble to its class.
    function automatic cmd_type_t classify(input logic [3:0] op);
        cmd_type_t t;
        if (op[3] == 1'b0)         t = CT_T1;
        else if (op[2] == 1'b0)    t = CT_T2;
        else if (op == OP_FORCE_INT) t = CT_T4;
        else                       t = CT_T3;
        return t;
    endfunction

endpackage

// File: rtl/fdc_addr_decode.sv
// Address window decode: claims an aligned eight-byte window at BASE and
// turns the read and write strobes into one strobe per register offset.
// Assumes: BASE is aligned to eight bytes; offsets NUM_REGS..7 have no register.
module fdc_addr_decode #(
    parameter int ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0FF8,
    parameter int NUM_REGS = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic                hit,
    output logic [NUM_REGS-1:0] wr_stb,
    output logic [NUM_REGS-1:0] rd_stb
);
    localparam int OFS_W = 3;

    // Window match on everything above the offset bits.
    always_comb hit = (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);

    // One strobe pair per register offset.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
        assign wr_stb[g] = wr_en && hit && (addr[OFS_W-1:0] == OFS_W'(g));
        assign rd_stb[g] = rd_en && hit && (addr[OFS_W-1:0] == OFS_W'(g));
    end

endmodule

// File: rtl/fdc_busy_timer.sv
// Busy countdown: a load sets the count, and the count then falls by one each cycle.
// Busy is high while the count is non-zero. A load of zero cancels at once.
// Assumes: load and its value come from the same command write.
module fdc_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: load has priority over the decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    // Busy level and the last-cycle marker of an unbroken countdown.
    always_comb begin
        busy   = (cnt_q != '0);
        expire = (cnt_q == CNT_W'(1)) && !load;
    end

    // R3: an undisturbed countdown falls by exactly one per cycle
    p_busy_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R7: a zero load ends busy on the next cycle
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> !busy);

endmodule

// File: rtl/fdc_xfer_ctrl.sv
// Transfer direction and DMA-ready control. It tracks the open direction and
// counts bytes within a sector. It raises the request when busy expires with a
// direction open, and drops it on an explicit drop or at the end of the sector.
// Assumes: a start and a cancel can arrive together; the start wins.
module fdc_xfer_ctrl
    import fdc_host_pkg::*;
#(
    parameter int SECTOR_BYTES = 256
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_in,
    input  logic      start_out,
    input  logic      cancel,
    input  logic      drop_req,
    input  logic      expire,
    input  logic      data_rd,
    input  logic      data_wr,
    output xfer_dir_t dir,
    output logic      dma_req,
    output logic      media_rd,
    output logic      media_wr
);
    localparam int IDX_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SECTOR_BYTES - 1);

    xfer_dir_t        dir_q;
    logic [IDX_W-1:0] idx_q;
    logic             dma_q;
    logic             step;
    logic             sector_end;

    // Byte handshake with the media stub and end-of-sector detection.
    always_comb begin
        media_rd   = data_rd && (dir_q == DIR_IN);
        media_wr   = data_wr && (dir_q == DIR_OUT);
        step       = media_rd || media_wr;
        sector_end = step && (idx_q == LAST);
    end

    // Direction and byte index: start, then cancel, then byte stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_NONE;
            idx_q <= '0;
        end else if (start_in || start_out) begin
            dir_q <= start_in ? DIR_IN : DIR_OUT;
            idx_q <= '0;
        end else if (cancel) begin
            dir_q <= DIR_NONE;
            idx_q <= '0;
        end else if (sector_end) begin
            dir_q <= DIR_NONE;
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // DMA-ready request: drops win over the raise on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                            dma_q <= 1'b0;
        else if (drop_req || sector_end)       dma_q <= 1'b0;
        else if (expire && dir_q != DIR_NONE)  dma_q <= 1'b1;
    end

    assign dir     = dir_q;
    assign dma_req = dma_q;

    // R5: the request only rises from an expiry with a direction open
    p_dma_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(expire && dir_q != DIR_NONE));

    // R9: the last byte of a sector closes the direction and drops the request
    p_sector_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_end && !start_in && !start_out) |=> (dir_q == DIR_NONE && !dma_req));

    // R3: a cancelling command closes the direction
    p_cancel_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !start_in && !start_out) |=> (dir_q == DIR_NONE));

endmodule

// File: rtl/fdc_host_regs.sv
// Host register window of a floppy controller. Offsets: 0 command (write) and
// status (read), 1 track, 2 sector, 3 data. Commands are classified, start a
// busy countdown, and sector commands open a transfer direction toward the media stub.
// Assumes: each access is a single-cycle strobe; rdata is valid during rd_en.
module fdc_host_regs
    import fdc_host_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0FF8,
    parameter int CNT_W        = 16,
    parameter int BUSY_CMD     = 20,
    parameter int BUSY_XFER    = 500,
    parameter int SECTOR_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        media_rdata,
    input  logic [5:0]        media_flags,
    output logic              media_rd,
    output logic              media_wr,
    output logic              dma_req,
    output logic              busy,
    output logic              motor_on,
    output logic [2:0]        cmd_type
);
    localparam int NUM_REGS = 4;
    localparam logic [CNT_W-1:0] LD_CMD  = CNT_W'(BUSY_CMD);
    localparam logic [CNT_W-1:0] LD_XFER = CNT_W'(BUSY_XFER);

    logic                hit;
    logic [NUM_REGS-1:0] wr_stb;
    logic [NUM_REGS-1:0] rd_stb;
    logic                cmd_wr;
    logic [3:0]          op;
    cmd_type_t           op_cls;
    logic                is_force;
    logic                is_sector;
    logic                is_restore;
    logic [CNT_W-1:0]    tmr_val;
    logic                expire;
    logic                drq;
    logic                drop_req;
    xfer_dir_t           dir;

    logic [7:0]          track_q;
    logic [7:0]          sector_q;
    logic [7:0]          data_q;
    logic [5:0]          stat_q;
    logic                motor_q;
    cmd_type_t           cls_q;

    fdc_addr_decode #(
        .ADDR_W  (ADDR_W),
        .BASE    (BASE),
        .NUM_REGS(NUM_REGS)
    ) u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .hit   (hit),
        .wr_stb(wr_stb),
        .rd_stb(rd_stb)
    );

    // Command decode for the byte being written.
    always_comb begin
        cmd_wr     = wr_stb[0];
        op         = wdata[7:4];
        op_cls     = classify(op);
        is_force   = cmd_wr && (op == OP_FORCE_INT);
        is_sector  = cmd_wr && (op_cls == CT_T2);
        is_restore = cmd_wr && (op == OP_RESTORE);
        tmr_val    = is_force ? '0 : (is_sector ? LD_XFER : LD_CMD);
    end

    fdc_busy_timer #(
        .CNT_W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_wr),
        .load_val(tmr_val),
        .busy    (busy),
        .expire  (expire)
    );

    // Data request bit and the request drop on a status read that shows it clear.
    always_comb begin
        drq      = (dir != DIR_NONE);
        drop_req = is_force || (rd_stb[0] && !drq);
    end

    fdc_xfer_ctrl #(
        .SECTOR_BYTES(SECTOR_BYTES)
    ) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_in (is_sector && !op[1]),
        .start_out(is_sector && op[1]),
        .cancel   (cmd_wr),
        .drop_req (drop_req),
        .expire   (expire),
        .data_rd  (rd_stb[3]),
        .data_wr  (wr_stb[3]),
        .dir      (dir),
        .dma_req  (dma_req),
        .media_rd (media_rd),
        .media_wr (media_wr)
    );

    // Command side effects: class, status flags and motor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q   <= CT_NONE;
            stat_q  <= '0;
            motor_q <= 1'b0;
        end else if (cmd_wr) begin
            cls_q <= op_cls;
            if (is_force)        stat_q <= '0;
            else if (is_sector)  stat_q <= media_flags;
            if (is_restore)      motor_q <= 1'b1;
        end
    end

    // Track and sector registers; restore zeroes the track.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track_q  <= '0;
            sector_q <= '0;
        end else begin
            if (is_restore)     track_q <= '0;
            else if (wr_stb[1]) track_q <= wdata;
            if (wr_stb[2])      sector_q <= wdata;
        end
    end

    // Data register: holds the last byte written or consumed from the media.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (wr_stb[3]) data_q <= wdata;
        else if (media_rd)  data_q <= media_rdata;
    end

    // Read multiplexer; unclaimed reads float high.
    always_comb begin
        unique case (1'b1)
            rd_stb[0]: rdata = {stat_q, drq, busy};
            rd_stb[1]: rdata = track_q;
            rd_stb[2]: rdata = sector_q;
            rd_stb[3]: rdata = (dir == DIR_IN) ? media_rdata : data_q;
            default:   rdata = 8'hFF;
        endcase
    end

    assign motor_on = motor_q;
    assign cmd_type = cls_q;

    // R1: reads outside the window return all ones
    p_outside_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |-> (rdata == 8'hFF));

    // R6: restore leaves track zero and the motor on
    p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_restore |=> (track_q == 8'h00 && motor_on));

    // R7: force interrupt clears busy, status and the request
    p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_force |=> (!busy && !dma_req && stat_q == '0));

    // R8: a status read with drq clear leaves the request low
    p_stat_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb[0] && !drq) |=> !dma_req);

endmodule

// File: tb/fdc_host_regs_tb.sv
// Directed bench for fdc_host_regs: one task per scenario, each checking its own results.
module fdc_host_regs_tb;

    localparam logic [15:0] A_CMD = 16'h0FF8;
    localparam logic [15:0] A_TRK = 16'h0FF9;
    localparam logic [15:0] A_SEC = 16'h0FFA;
    localparam logic [15:0] A_DAT = 16'h0FFB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  media_rdata = '0;
    logic [5:0]  media_flags = '0;
    logic        media_rd;
    logic        media_wr;
    logic        dma_req;
    logic        busy;
    logic        motor_on;
    logic [2:0]  cmd_type;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    fdc_host_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wdata      (wdata),
        .rdata      (rdata),
        .media_rdata(media_rdata),
        .media_flags(media_flags),
        .media_rd   (media_rd),
        .media_wr   (media_wr),
        .dma_req    (dma_req),
        .busy       (busy),
        .motor_on   (motor_on),
        .cmd_type   (cmd_type)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(!busy && !dma_req && !motor_on, "R10 outputs", {busy, dma_req, motor_on}, 0);
        check(cmd_type == 3'd0, "R10 cmd_type", cmd_type, 0);
        bus_rd(A_CMD, d); check(d == 8'h00, "R10 status", d, 0);
        bus_rd(A_TRK, d); check(d == 8'h00, "R10 track", d, 0);
        bus_rd(A_SEC, d); check(d == 8'h00, "R10 sector", d, 0);
    endtask

    task automatic t_window();
        logic [7:0] d;
        bus_wr(A_TRK, 8'h33);
        bus_wr(16'h0FE9, 8'h55);
        bus_wr(16'h1FF9, 8'h66);
        bus_rd(A_TRK, d); check(d == 8'h33, "R1 outside write ignored", d, 8'h33);
        bus_rd(16'h1000, d); check(d == 8'hFF, "R1 outside read", d, 8'hFF);
        bus_rd(16'h0FFD, d); check(d == 8'hFF, "R1 offset 5 read", d, 8'hFF);
    endtask

    task automatic t_track_sector();
        logic [7:0] d;
        bus_wr(A_TRK, 8'hA5); bus_wr(A_SEC, 8'h3C);
        bus_rd(A_TRK, d); check(d == 8'hA5, "R11 track", d, 8'hA5);
        bus_rd(A_SEC, d); check(d == 8'h3C, "R11 sector", d, 8'h3C);
    endtask

    task automatic t_classes();
        int bad = 0;
        int exp;
        for (int k = 0; k < 16; k++) begin
            bus_wr(A_CMD, 8'(k << 4));
            exp = (k < 8) ? 1 : (k < 12) ? 2 : (k == 13) ? 4 : 3;
            if (cmd_type != 3'(exp)) begin
                bad++;
                $display("FAIL R2 op %0d: got %0d expected %0d", k, cmd_type, exp);
            end
        end
        n_run++;
        if (bad != 0) n_fail++;
        bus_wr(A_CMD, 8'hD0);
    endtask

    task automatic t_busy_short();
        int n;
        bus_wr(A_CMD, 8'h10);
        check(busy, "R3 busy after command", busy, 1);
        wait_busy(n);
        check(n == 20, "R3 busy length", n, 20);
        check(!dma_req, "R5 no request without direction", dma_req, 0);
    endtask

    task automatic t_restore();
        logic [7:0] d;
        bus_wr(A_TRK, 8'h27);
        bus_wr(A_CMD, 8'h00);
        bus_rd(A_TRK, d); check(d == 8'h00, "R6 track cleared", d, 0);
        check(motor_on, "R6 motor on", motor_on, 1);
    endtask

    task automatic t_sector_read();
        logic [7:0] d;
        int n;
        int bad = 0;
        int strobes = 0;
        media_flags = 6'b101001;
        bus_wr(A_CMD, 8'h80);
        check(!dma_req, "R5 request low while busy", dma_req, 0);
        wait_busy(n);
        check(n == 500, "R4 sector busy length", n, 500);
        check(dma_req, "R5 request with busy fall", dma_req, 1);
        bus_rd(A_CMD, d); check(d == 8'hA6, "R4 R8 status format", d, 8'hA6);
        check(dma_req, "R8 request kept while drq set", dma_req, 1);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            media_rdata = 8'(i ^ 8'h5A);
            addr = A_DAT; rd_en = 1'b1;
            #1;
            if (rdata != 8'(i ^ 8'h5A)) bad++;
            if (media_rd) strobes++;
            @(negedge clk);
            rd_en = 1'b0;
        end
        check(bad == 0, "R9 inbound bytes", bad, 0);
        check(strobes == 256, "R9 media_rd pulses", strobes, 256);
        check(!dma_req, "R9 request dropped at sector end", dma_req, 0);
        bus_rd(A_CMD, d); check(d[1] == 1'b0, "R9 direction closed", d, 8'hA4);
        media_flags = '0;
    endtask

    task automatic t_sector_write();
        int n;
        int strobes = 0;
        bus_wr(A_CMD, 8'hA0);
        wait_busy(n);
        check(dma_req, "R4 R5 outbound request", dma_req, 1);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            addr = A_DAT; wdata = 8'(i); wr_en = 1'b1;
            #1;
            if (media_wr) strobes++;
            @(negedge clk);
            wr_en = 1'b0;
        end
        check(strobes == 256, "R9 media_wr pulses", strobes, 256);
        check(!dma_req, "R9 outbound end drops request", dma_req, 0);
    endtask

    task automatic t_force();
        logic [7:0] d;
        int n;
        media_flags = 6'h3F;
        bus_wr(A_CMD, 8'h90);
        repeat (10) @(negedge clk);
        bus_wr(A_CMD, 8'hD0);
        check(!busy, "R7 busy cleared", busy, 0);
        bus_rd(A_CMD, d); check(d == 8'h00, "R7 status cleared", d, 0);
        bus_wr(A_CMD, 8'h80);
        wait_busy(n);
        check(dma_req, "R7 setup request", dma_req, 1);
        bus_wr(A_CMD, 8'hD0);
        check(!dma_req, "R7 request dropped", dma_req, 0);
        media_flags = '0;
    endtask

    task automatic t_cancel_keeps_req();
        logic [7:0] d;
        int n;
        bus_wr(A_CMD, 8'h80);
        wait_busy(n);
        bus_wr(A_CMD, 8'h10);
        check(dma_req, "R8 cancel keeps request", dma_req, 1);
        wait_busy(n);
        check(dma_req, "R8 request held after plain busy", dma_req, 1);
        bus_rd(A_CMD, d);
        check(d[1] == 1'b0, "R3 direction cancelled", d, 0);
        check(!dma_req, "R8 status read drops request", dma_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_track_sector();
        t_classes();
        t_busy_short();
        t_restore();
        t_sector_read();
        t_sector_write();
        t_force();
        t_cancel_keeps_req();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule